// File: doc/BRIEF.md
# Remote DMA Word Data Port

This block gives a host indirect, word-wide access to a local packet buffer. The host never presents a buffer address. It first programs a 16-bit start address and a 16-bit byte count. Each register is split into a low byte and a high byte, and both sit in a small 16-entry page-0 register file that the block owns. The host then streams 16-bit words through a single data port. Each word moves between the host and the buffer at the current start address. After it, the hardware steps the address up by two and the count down by two, and writes both back into the register file.

Every data-port access is gated. The data configuration register must select word transfers, and the command register must show the start bit together with the direction bit that matches the access. A gated-off access is ignored. A second port offset is a board reset port: writing it latches a byte, and reading it returns that byte and pulses a board reset event. The buffer size is the parameter `BUF_BYTES`. The target configuration uses 32768 bytes; the default is 4096 bytes.

Accesses arrive on a valid/ready request channel. `acc_ready` drops for any cycle in which the host register-write port is active, so that register file updates never collide. Reads answer on `rsp_valid`/`rsp_data` exactly one cycle after acceptance. The response channel has no back-pressure, so the host must take it in that cycle. Every accepted read produces one response.

Top module: `rdma_word_port`

## Requirements
- R1: An accepted, enabled write to data offset 0x0 stores `acc_wdata[7:0]` at the start address and `acc_wdata[15:8]` at start address plus one.
- R2: An accepted read produces `rsp_valid` for exactly one cycle, one cycle after acceptance. For an enabled data read, `rsp_data` holds the byte at the start address in bits 7:0 and the byte at the next address in bits 15:8.
- R3: After each enabled data access, the start address (register 0x8 low, 0x9 high) rises by 2 and the byte count (0xA low, 0xB high) falls by 2, modulo 2^16. Both are readable through `reg_rdata`.
- R4: If bit 0 of the configuration register (0xE) is clear, data accesses are ignored. Nothing is stored, address and count are unchanged, no error is raised, and a read returns 0.
- R5: A data write needs command register (0x0) bits 1 and 4 set, and a data read needs bits 1 and 3 set. Otherwise the access is ignored as in R4.
- R6: An otherwise enabled data access whose start address is not below `BUF_BYTES` pulses `err` one cycle after acceptance, and is ignored. The byte at start address plus one wraps to address 0 at the buffer's end.
- R7: When an enabled data access leaves the byte count at zero, bit 6 of the status register (0x7) is set. A host write to 0x7 clears each bit written as one.
- R8: A write to offset 0xF latches `acc_wdata[7:0]`. A read of 0xF returns that byte zero-extended and pulses `board_rst` in the response cycle. A write to 0xF does not pulse `board_rst`.
- R9: An access to any offset other than 0x0 and 0xF pulses `err` one cycle after acceptance and has no other effect. A read there returns 0.
- R10: While `reg_we` is high, `acc_ready` is low and no access is accepted.
- R11: After reset, all registers read 0, and `rsp_valid`, `err` and `board_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted this cycle when high with valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 4 | Port offset (0x0 data, 0xF board reset) |
| acc_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Read response word |
| err | output | 1 | Error pulse for bad offset or out-of-range address |
| board_rst | output | 1 | Board reset event pulse |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register write offset |
| reg_wdata | input | 8 | Host register write data |
| reg_raddr | input | 4 | Register readback offset |
| reg_rdata | output | 8 | Register readback data (combinational) |

## Verification
The assertions check on every cycle that:
- each accepted read is answered exactly one cycle later;
- enabled accesses step the address and count by two;
- a word-mode-off access leaves them untouched;
- bad offsets raise `err`;
- register writes block acceptance;
- `board_rst` only follows a reset-port read.

Only the bench's scenarios can show the stored contents: the byte order, the wrap at the buffer's end, the reset-port latch value, and the setting and clearing of the done bit. They are compared against a byte-level model over filled-buffer, directed and random access patterns.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] REG_CMD    = 4'h0;
  localparam logic [3:0] REG_STAT   = 4'h7;
  localparam logic [3:0] REG_SA_LO  = 4'h8;
  localparam logic [3:0] REG_SA_HI  = 4'h9;
  localparam logic [3:0] REG_CNT_LO = 4'hA;
  localparam logic [3:0] REG_CNT_HI = 4'hB;
  localparam logic [3:0] REG_CFG    = 4'hE;
  localparam logic [3:0] PORT_DATA  = 4'h0;
  localparam logic [3:0] PORT_BRST  = 4'hF;
  localparam int CMD_GO_BIT   = 1;
  localparam int CMD_RD_BIT   = 3;
  localparam int CMD_WR_BIT   = 4;
  localparam int CFG_WORD_BIT = 0;
  localparam int STAT_DONE_BIT = 6;
  typedef enum logic [1:0] {RSP_ZERO, RSP_MEM, RSP_LATCH} rsp_sel_e;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [7:0]  host_wdata,
  input  logic [3:0]  host_raddr,
  output logic [7:0]  host_rdata,
  input  logic        upd,
  input  logic [15:0] upd_sa,
  input  logic [15:0] upd_cnt,
  input  logic        set_done,
  output logic        cmd_go,
  output logic        cmd_rd,
  output logic        cmd_wr,
  output logic        cfg_word,
  output logic [15:0] cur_sa,
  output logic [15:0] cur_cnt
);
  localparam int NREG = 16;
  logic [7:0] q   [NREG];
  logic [7:0] nxt [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) nxt[i] = q[i];
    if (upd) begin
      nxt[REG_SA_LO]  = upd_sa[7:0];
      nxt[REG_SA_HI]  = upd_sa[15:8];
      nxt[REG_CNT_LO] = upd_cnt[7:0];
      nxt[REG_CNT_HI] = upd_cnt[15:8];
    end
    if (set_done) nxt[REG_STAT][STAT_DONE_BIT] = 1'b1;
    if (host_we) begin
      if (host_addr == REG_STAT) nxt[REG_STAT] = q[REG_STAT] & ~host_wdata;
      else nxt[host_addr] = host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) q[i] <= nxt[i];
    end
  end

  assign host_rdata = q[host_raddr];
  assign cmd_go   = q[REG_CMD][CMD_GO_BIT];
  assign cmd_rd   = q[REG_CMD][CMD_RD_BIT];
  assign cmd_wr   = q[REG_CMD][CMD_WR_BIT];
  assign cfg_word = q[REG_CFG][CFG_WORD_BIT];
  assign cur_sa   = {q[REG_SA_HI], q[REG_SA_LO]};
  assign cur_cnt  = {q[REG_CNT_HI], q[REG_CNT_LO]};
endmodule

// File: rtl/rdma_bank.sv
module rdma_bank #(
  parameter int DEPTH = 2048,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/rdma_word_port.sv
module rdma_word_port
  import rdma_pkg::*;
#(
  parameter int BUF_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  output logic        acc_ready,
  input  logic        acc_write,
  input  logic [3:0]  acc_off,
  input  logic [15:0] acc_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        err,
  output logic        board_rst,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic [3:0]  reg_raddr,
  output logic [7:0]  reg_rdata
);
  localparam int AW   = $clog2(BUF_BYTES);
  localparam int HALF = BUF_BYTES / 2;
  localparam int IW   = AW - 1;
  localparam logic [16:0] LIMIT = 17'(BUF_BYTES);

  logic        cmd_go, cmd_rd, cmd_wr, cfg_word;
  logic [15:0] cur_sa, cur_cnt;
  logic        fire, is_data, is_brst, bad_off, dir_ok, in_range, enabled, go;
  logic [AW-1:0] a0, a1;
  logic [7:0]  bank_rd [2];
  logic [7:0]  latch_q;
  logic        swap_q, rsp_q, err_q, brst_q;
  rsp_sel_e    sel_q;

  assign acc_ready = !reg_we;
  assign fire      = acc_valid && acc_ready;
  assign is_data   = (acc_off == PORT_DATA);
  assign is_brst   = (acc_off == PORT_BRST);
  assign bad_off   = !is_data && !is_brst;
  assign dir_ok    = cmd_go && (acc_write ? cmd_wr : cmd_rd);
  assign in_range  = ({1'b0, cur_sa} < LIMIT);
  assign enabled   = fire && is_data && cfg_word && dir_ok;
  assign go        = enabled && in_range;
  assign a0        = cur_sa[AW-1:0];
  assign a1        = a0 + {{(AW-1){1'b0}}, 1'b1};

  rdma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(reg_we), .host_addr(reg_addr), .host_wdata(reg_wdata),
    .host_raddr(reg_raddr), .host_rdata(reg_rdata),
    .upd(go), .upd_sa(cur_sa + 16'd2), .upd_cnt(cur_cnt - 16'd2),
    .set_done(go && (cur_cnt == 16'd2)),
    .cmd_go(cmd_go), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cfg_word(cfg_word),
    .cur_sa(cur_sa), .cur_cnt(cur_cnt)
  );

  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic          own_lo;
    logic [IW-1:0] idx;
    assign own_lo = (a0[0] == 1'(k));
    assign idx    = own_lo ? a0[AW-1:1] : a1[AW-1:1];
    rdma_bank #(.DEPTH(HALF)) u_bank (
      .clk(clk),
      .we(go && acc_write),
      .re(go && !acc_write),
      .idx(idx),
      .wdata(own_lo ? acc_wdata[7:0] : acc_wdata[15:8]),
      .rdata(bank_rd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      swap_q  <= 1'b0;
      rsp_q   <= 1'b0;
      err_q   <= 1'b0;
      brst_q  <= 1'b0;
      sel_q   <= RSP_ZERO;
    end else begin
      rsp_q  <= fire && !acc_write;
      err_q  <= (fire && bad_off) || (enabled && !in_range);
      brst_q <= fire && is_brst && !acc_write;
      swap_q <= a0[0];
      if (fire && is_brst && acc_write) latch_q <= acc_wdata[7:0];
      if (go && !acc_write)           sel_q <= RSP_MEM;
      else if (fire && is_brst)       sel_q <= RSP_LATCH;
      else                            sel_q <= RSP_ZERO;
    end
  end

  always_comb begin
    unique case (sel_q)
      RSP_MEM:   rsp_data = swap_q ? {bank_rd[0], bank_rd[1]} : {bank_rd[1], bank_rd[0]};
      RSP_LATCH: rsp_data = {8'h00, latch_q};
      default:   rsp_data = 16'h0000;
    endcase
  end

  assign rsp_valid = rsp_q;
  assign err       = err_q;
  assign board_rst = brst_q;
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic        acc_write,
  input logic [3:0]  acc_off,
  input logic        reg_we,
  input logic        rsp_valid,
  input logic        err,
  input logic        board_rst,
  input logic        cmd_go,
  input logic        cmd_rd,
  input logic        cmd_wr,
  input logic        cfg_word,
  input logic        in_range,
  input logic [15:0] cur_sa,
  input logic [15:0] cur_cnt
);
  logic acc_fire, data_on, word_off;
  assign acc_fire = acc_valid && acc_ready;
  assign data_on  = acc_fire && acc_off == 4'h0 && cfg_word && cmd_go &&
                    (acc_write ? cmd_wr : cmd_rd) && in_range;
  assign word_off = acc_fire && acc_off == 4'h0 && !cfg_word;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_write |=> rsp_valid); // R2
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_fire && !acc_write)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_on |=> cur_sa == $past(cur_sa) + 16'd2); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_on |=> cur_cnt == $past(cur_cnt) - 16'd2); // R3
  AST_WORD_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    word_off |=> $stable(cur_sa) && $stable(cur_cnt) && !err); // R4
  AST_BAD_OFF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_off != 4'h0 && acc_off != 4'hF |=> err); // R9
  AST_REG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !acc_ready); // R10
  AST_BRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> $past(acc_fire && !acc_write && acc_off == 4'hF) && rsp_valid); // R8
endmodule

bind rdma_word_port rdma_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_write(acc_write), .acc_off(acc_off), .reg_we(reg_we),
  .rsp_valid(rsp_valid), .err(err), .board_rst(board_rst),
  .cmd_go(cmd_go), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cfg_word(cfg_word),
  .in_range(in_range), .cur_sa(cur_sa), .cur_cnt(cur_cnt)
);

// File: tb/tb_rdma_word_port.sv
module tb_rdma_word_port;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 4096;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [3:0] acc_off = 0;
  logic [15:0] acc_wdata = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0, reg_raddr = 0;
  logic [7:0] reg_wdata = 0;
  logic acc_ready, rsp_valid, err, board_rst;
  logic [15:0] rsp_data;
  logic [7:0] reg_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mem [BUF];
  logic [7:0] mregs [16];
  logic [7:0] mlatch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_word_port #(.BUF_BYTES(BUF)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 4'h7) mregs[a] = mregs[a] & ~d; else mregs[a] = d;
  endtask

  task automatic rreg(logic [3:0] a, output logic [7:0] v);
    reg_raddr = a; #1; v = reg_rdata;
  endtask

  task automatic set_ptr(logic [15:0] sa, logic [15:0] cnt);
    wreg(4'h8, sa[7:0]); wreg(4'h9, sa[15:8]);
    wreg(4'hA, cnt[7:0]); wreg(4'hB, cnt[15:8]);
  endtask

  // model from the requirements
  task automatic model(bit w, logic [3:0] off, logic [15:0] d,
                       output logic [15:0] rd, output bit e, output bit br);
    logic [15:0] sa, cnt;
    bit ok;
    rd = 0; e = 0; br = 0;
    sa  = {mregs[9], mregs[8]};
    cnt = {mregs[11], mregs[10]};
    if (off == 4'h0) begin
      ok = mregs[14][0] && mregs[0][1] && (w ? mregs[0][4] : mregs[0][3]);
      if (ok && sa >= BUF) e = 1;
      else if (ok) begin
        if (w) begin mem[sa] = d[7:0]; mem[(sa + 1) % BUF] = d[15:8]; end
        else rd = {mem[(sa + 1) % BUF], mem[sa]};
        sa = sa + 2; cnt = cnt - 2;
        if (cnt == 0) mregs[7][6] = 1'b1;
        mregs[8] = sa[7:0]; mregs[9] = sa[15:8];
        mregs[10] = cnt[7:0]; mregs[11] = cnt[15:8];
      end
    end else if (off == 4'hF) begin
      if (w) mlatch = d[7:0]; else begin rd = {8'h00, mlatch}; br = 1; end
    end else e = 1;
  endtask

  task automatic acc(string tag, bit w, logic [3:0] off, logic [15:0] d);
    logic [15:0] erd; bit ee, ebr; logic [7:0] v;
    model(w, off, d, erd, ee, ebr);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_off = off; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0;
    chk({tag, " R2 rsp_valid"}, rsp_valid, !w);
    if (!w) chk({tag, " R2 data"}, rsp_data, erd);
    chk({tag, " R6/R9 err"}, err, ee);
    chk({tag, " R8 board_rst"}, board_rst, ebr);
    for (int i = 7; i <= 11; i++) begin
      rreg(4'(i), v);
      chk({tag, " R3/R7 reg"}, v, mregs[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mregs[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 err", err, 0);
    chk("R11 board_rst", board_rst, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin rreg(4'(i), v); chk("R11 reg", v, 0); end
    chk("R10 ready idle", acc_ready, 1);

    // R1 R3 R7: fill whole buffer, count reaches zero on last word
    wreg(4'hE, 8'h01); wreg(4'h0, 8'h12);
    set_ptr(16'h0000, 16'(BUF));
    for (int i = 0; i < BUF / 2; i++) acc("R1 fill", 1, 4'h0, 16'($urandom));
    rreg(4'h7, v); chk("R7 done set", v[6], 1);
    wreg(4'h7, 8'h40);
    rreg(4'h7, v); chk("R7 done cleared", v, 0);

    // R2 R6: read at last byte wraps high byte to address 0
    wreg(4'h0, 8'h0A);
    set_ptr(16'(BUF - 1), 16'h0010);
    acc("R6 wrap read", 0, 4'h0, 0);
    // R6 out of range
    acc("R6 out of range", 0, 4'h0, 0);
    acc("R6 out of range wr", 1, 4'h0, 16'hBEEF);
    // R4 word mode off
    set_ptr(16'h0100, 16'h0040);
    wreg(4'hE, 8'h00);
    acc("R4 ignored read", 0, 4'h0, 0);
    wreg(4'h0, 8'h12);
    acc("R4 ignored write", 1, 4'h0, 16'h5A5A);
    wreg(4'hE, 8'h01);
    // R5 direction mismatch and missing start
    acc("R5 read in write dir", 0, 4'h0, 0);
    wreg(4'h0, 8'h10);
    acc("R5 write no start", 1, 4'h0, 16'h1111);
    wreg(4'h0, 8'h0A);
    acc("R4/R5 readback", 0, 4'h0, 0);
    // R8 reset port
    acc("R8 latch", 1, 4'hF, 16'hABCD);
    acc("R8 readback", 0, 4'hF, 0);
    // R9 bad offsets
    acc("R9 bad read", 0, 4'h5, 0);
    acc("R9 bad write", 1, 4'h3, 16'h7777);
    // R10 register write blocks acceptance
    @(negedge clk);
    reg_we = 1; reg_addr = 4'h3; reg_wdata = 8'h99;
    acc_valid = 1; acc_write = 0; acc_off = 4'h0;
    #1 chk("R10 ready low", acc_ready, 0);
    @(negedge clk);
    reg_we = 0; acc_valid = 0; mregs[3] = 8'h99;
    chk("R10 no response", rsp_valid, 0);
    rreg(4'h3, v); chk("R10 reg written", v, 8'h99);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom % 8;
      wreg(4'h0, (r < 4) ? 8'h12 : 8'h0A);
      wreg(4'hE, (r == 7) ? 8'h00 : 8'h01);
      set_ptr(16'($urandom % (BUF + 4)), 16'(2 * ($urandom % 4)));
      for (int k = 0; k < 1 + ($urandom % 4); k++) begin
        int o;
        o = $urandom % 10;
        acc("R1/R2/R3 random", ($urandom % 2) == 1,
            (o < 8) ? 4'h0 : ((o == 8) ? 4'hF : 4'($urandom)), 16'($urandom));
      end
      if (mregs[7][6]) wreg(4'h7, 8'h40);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule